// File: doc/BRIEF.md
# Register-List Multi-Load Sequencer

This block loads a group of registers from consecutive memory locations. A 16-bit selection mask names the registers. A start strobe captures the mask, the start address and the operand size. The sequencer then walks the mask from the lowest bit to the highest. For each set bit it performs one read on a request/acknowledge memory port and one write on the register-file port. Clear bits are passed over without any memory cycle.

When the walk is finished, the block reports the address that follows the last operand. The surrounding core can use that value to update the base register. It then pulses a completion strobe.

Register indices 0 to 7 form the data group and indices 8 to 15 form the address group. The group decides how a 16-bit operand is presented on the register write port.

Top module: `reg_list_loader`

## Requirements
- R1: While rst_ni is low, and after reset until a start is accepted, busy_o, done_o, mem_req_o and rf_we_o are all 0.
- R2: start_i is accepted only when busy_o is 0. At acceptance, base_addr_i, reg_mask_i and long_i are captured, so later changes on those inputs have no effect on the operation. A start_i pulse while busy_o is 1 is ignored: it produces no extra register writes and no second done_o.
- R3: Mask bits are visited in ascending order, bit 0 first. Each set bit at position k causes exactly one memory read and exactly one register write with rf_idx_o = k. Clear bits cause neither.
- R4: The first read uses the captured start address. Each following read address is the previous one plus 4 when long_i was 1 and plus 2 when long_i was 0, wrapping modulo 2^AW.
- R5: mem_req_o stays high with a stable mem_addr_o until mem_ack_i is sampled high. No new request is raised before that acknowledge. The register write follows one cycle after the acknowledge.
- R6: In a 32-bit load (long_i = 1), rf_wdata_o equals mem_rdata_i as captured at the acknowledge, and rf_lo_only_o is 0.
- R7: In a 16-bit load (long_i = 0) into index 8 to 15, rf_wdata_o is mem_rdata_i[15:0] sign-extended to 32 bits, and rf_lo_only_o is 0.
- R8: In a 16-bit load into index 0 to 7, rf_wdata_o is mem_rdata_i[15:0] zero-extended, and rf_lo_only_o is 1. The register file should then update only the low half.
- R9: done_o is high for exactly one cycle per accepted start. While done_o is high, final_addr_o equals the start address plus (number of set mask bits) times the step. busy_o is 0 in the following cycle.
- R10: An all-zero mask completes with no memory reads and no register writes. final_addr_o then equals the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| base_addr_i | input | AW | Start address |
| reg_mask_i | input | 16 | Register selection mask, bit k selects register k |
| long_i | input | 1 | 1 selects 32-bit operands, 0 selects 16-bit operands |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_ack_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_idx_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| rf_lo_only_o | output | 1 | Only bits 15:0 of the write are meaningful |
| final_addr_o | output | AW | Address following the last operand, valid with done_o |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | Operation in progress |

## Verification
A stale or wrongly cleared mask bit shows up in the very next register write. It appears as a repeated or out-of-order rf_idx_o, or as a write count that differs from the mask population. A wrong address step is visible on mem_addr_o at the second request, and again on final_addr_o at done_o. A state machine that leaves its read state early or late shows up on the write port one cycle after the acknowledge. It appears as data that does not match the word stored at the request address. Stretched acknowledge latencies, address wrap at the top of the space, and a start pulse injected mid-run each stress one of these paths.

// File: rtl/reg_list_pkg.sv
package reg_list_pkg;
  localparam int unsigned MASK_W = 16;
  localparam int unsigned IDX_W  = $clog2(MASK_W);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } ld_state_e;
endpackage

// File: rtl/mask_scan.sv
module mask_scan #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [W-1:0] lowest;

  assign lowest = mask_i & (~mask_i + W'(1));
  assign any_o  = |mask_i;

  // one-hot to binary: OR of positions per output bit
  for (genvar b = 0; b < IW; b++) begin : g_enc
    logic [W-1:0] sel;
    for (genvar p = 0; p < W; p++) begin : g_pos
      assign sel[p] = lowest[p] & ((p >> b) & 1) == 1;
    end
    assign idx_o[b] = |sel;
  end
endmodule

// File: rtl/addr_step.sv
module addr_step #(
  parameter int unsigned AW = 24
) (
  input  logic [AW-1:0] addr_i,
  input  logic          long_i,
  output logic [AW-1:0] next_o
);
  localparam logic [AW-1:0] STEP_L = AW'(4);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  assign next_o = addr_i + (long_i ? STEP_L : STEP_W);
endmodule

// File: rtl/load_shaper.sv
module load_shaper
  import reg_list_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic [DW-1:0] rdata_i,
  input  logic          long_i,
  input  logic [IW-1:0] idx_i,
  output logic [DW-1:0] wdata_o,
  output logic          lo_only_o
);
  localparam int unsigned HW = DW / 2;
  logic addr_grp;

  assign addr_grp = idx_i[IW-1];

  always_comb begin
    if (long_i) begin
      wdata_o   = rdata_i;
      lo_only_o = 1'b0;
    end else if (addr_grp) begin
      wdata_o   = {{HW{rdata_i[HW-1]}}, rdata_i[HW-1:0]};
      lo_only_o = 1'b0;
    end else begin
      wdata_o   = {{HW{1'b0}}, rdata_i[HW-1:0]};
      lo_only_o = 1'b1;
    end
  end
endmodule

// File: rtl/reg_list_loader.sv
module reg_list_loader
  import reg_list_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [AW-1:0]       base_addr_i,
  input  logic [MASK_W-1:0]   reg_mask_i,
  input  logic                long_i,
  output logic                mem_req_o,
  output logic [AW-1:0]       mem_addr_o,
  input  logic                mem_ack_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                rf_we_o,
  output logic [IDX_W-1:0]    rf_idx_o,
  output logic [DATA_W-1:0]   rf_wdata_o,
  output logic                rf_lo_only_o,
  output logic [AW-1:0]       final_addr_o,
  output logic                done_o,
  output logic                busy_o
);
  ld_state_e           state_q, state_d;
  logic [MASK_W-1:0]   mask_q;
  logic [AW-1:0]       addr_q;
  logic                long_q;
  logic [IDX_W-1:0]    idx_q;
  logic [DATA_W-1:0]   data_q;

  logic                scan_any;
  logic [IDX_W-1:0]    scan_idx;
  logic [AW-1:0]       addr_next;

  mask_scan #(.W(MASK_W), .IW(IDX_W)) u_scan (
    .mask_i (mask_q),
    .any_o  (scan_any),
    .idx_o  (scan_idx)
  );

  addr_step #(.AW(AW)) u_step (
    .addr_i (addr_q),
    .long_i (long_q),
    .next_o (addr_next)
  );

  load_shaper #(.DW(DATA_W), .IW(IDX_W)) u_shape (
    .rdata_i   (data_q),
    .long_i    (long_q),
    .idx_i     (idx_q),
    .wdata_o   (rf_wdata_o),
    .lo_only_o (rf_lo_only_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SCAN;
      ST_SCAN:  state_d = scan_any ? ST_READ : ST_DONE;
      ST_READ:  if (mem_ack_i) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_SCAN;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      long_q  <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mask_q <= reg_mask_i;
          addr_q <= base_addr_i;
          long_q <= long_i;
        end
        ST_SCAN:  if (scan_any) idx_q <= scan_idx;
        ST_READ:  if (mem_ack_i) data_q <= mem_rdata_i;
        ST_WRITE: begin
          mask_q <= mask_q & ~(MASK_W'(1) << idx_q);
          addr_q <= addr_next;
        end
        default: ;
      endcase
    end
  end

  assign mem_req_o    = (state_q == ST_READ);
  assign mem_addr_o   = addr_q;
  assign rf_we_o      = (state_q == ST_WRITE);
  assign rf_idx_o     = idx_q;
  assign final_addr_o = addr_q;
  assign done_o       = (state_q == ST_DONE);
  assign busy_o       = (state_q != ST_IDLE);
endmodule

// File: rtl/reg_list_loader_chk.sv
module reg_list_loader_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          long_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          rf_we_o,
  input logic [3:0]    rf_idx_o,
  input logic [AW-1:0] final_addr_o,
  input logic          done_o,
  input logic          busy_o
);
  logic          seen_q, long_q;
  logic [3:0]    last_idx_q;
  logic [AW-1:0] exp_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      long_q     <= 1'b0;
      last_idx_q <= '0;
      exp_addr_q <= '0;
    end else if (start_i && !busy_o) begin
      seen_q <= 1'b0;
      long_q <= long_i;
    end else if (rf_we_o) begin
      seen_q     <= 1'b1;
      last_idx_q <= rf_idx_o;
      exp_addr_q <= mem_addr_o + (long_q ? AW'(4) : AW'(2));
    end
  end

  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !busy_o && !done_o && !mem_req_o && !rf_we_o);

  // R3
  ascending_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && seen_q |-> rf_idx_o > last_idx_q);

  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && seen_q |-> mem_addr_o == exp_addr_q);

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  // R5
  write_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> rf_we_o && !mem_req_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R9
  final_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && seen_q |-> final_addr_o == exp_addr_q);
endmodule

bind reg_list_loader reg_list_loader_chk #(.AW(AW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .long_i       (long_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .rf_we_o      (rf_we_o),
  .rf_idx_o     (rf_idx_o),
  .final_addr_o (final_addr_o),
  .done_o       (done_o),
  .busy_o       (busy_o)
);

// File: tb/reg_list_loader_tb.sv
`timescale 1ns/1ps
module reg_list_loader_tb_top;
  localparam int unsigned AW = 24;
  localparam int unsigned NV = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] base_addr;
  logic [15:0]   mask;
  logic          long_sel;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack;
  logic [31:0]   mem_rdata;
  logic          rf_we;
  logic [3:0]    rf_idx;
  logic [31:0]   rf_wdata;
  logic          rf_lo;
  logic [AW-1:0] final_addr;
  logic          done;
  logic          busy;

  always #2 clk = ~clk;

  reg_list_loader #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base_addr),
    .reg_mask_i(mask), .long_i(long_sel), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .rf_we_o(rf_we), .rf_idx_o(rf_idx),
    .rf_wdata_o(rf_wdata), .rf_lo_only_o(rf_lo), .final_addr_o(final_addr),
    .done_o(done), .busy_o(busy)
  );

  int n_chk = 0;
  int n_fail = 0;

  // {long, mask, start address}
  localparam logic [AW+16:0] VEC [NV] = '{
    {1'b1, 16'h0001, 24'h000100},
    {1'b1, 16'hFFFF, 24'h002000},
    {1'b0, 16'hFFFF, 24'h00A000},
    {1'b0, 16'hA5A5, 24'h003000},
    {1'b1, 16'h8100, 24'hFFFFF8},
    {1'b0, 16'h0F0F, 24'h00FFFE},
    {1'b1, 16'h5500, 24'h004000},
    {1'b0, 16'hF000, 24'h007FF0}
  };

  // bench-side memory and write log
  int            lat_cfg = 0;
  int            wait_cnt = 0;
  int            rd_cnt, n_wr, done_cnt;
  bit            req_err;
  logic [AW-1:0] req_addr;
  logic [3:0]    log_idx [16];
  logic [31:0]   log_data[16];
  logic          log_lo  [16];
  logic [AW-1:0] fin_addr;

  function automatic logic [31:0] mem_model(input logic [AW-1:0] a);
    return {a[15:0] + 16'h1357, a[15:0] ^ 16'h8421};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_ack = 1'b0;
    mem_rdata = 32'hDEAD_BEEF;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (wait_cnt == 0) req_addr = mem_addr;
        else if (mem_addr != req_addr) req_err = 1'b1;
        if (wait_cnt < lat_cfg) begin
          wait_cnt++;
        end else begin
          mem_ack = 1'b1;
          mem_rdata = mem_model(mem_addr);
          rd_cnt++;
          wait_cnt = 0;
        end
      end else begin
        if (mem_ack && mem_req) req_err = 1'b1;
        mem_ack = 1'b0;
        mem_rdata = 32'hDEAD_BEEF;
      end
    end
  end

  // write and completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rf_we) begin
        if (n_wr < 16) begin
          log_idx[n_wr] = rf_idx;
          log_data[n_wr] = rf_wdata;
          log_lo[n_wr] = rf_lo;
        end
        n_wr++;
      end
      if (done) begin
        done_cnt++;
        fin_addr = final_addr;
      end
    end
  end

  task automatic run_op(input logic [AW-1:0] a, input logic [15:0] m, input logic lg,
                        input int lat, input bit inject);
    logic [AW-1:0] ea;
    logic [31:0]   d, ed;
    int            j, pc;
    n_wr = 0; rd_cnt = 0; done_cnt = 0; req_err = 1'b0; lat_cfg = lat;
    base_addr = a; mask = m; long_sel = lg; start = 1'b1;
    @(negedge clk);
    start = 1'b0; base_addr = 24'h5A5A5A; mask = 16'hFFFF; long_sel = ~lg;
    if (inject) begin
      @(negedge clk);
      start = 1'b1; mask = 16'h00F0; base_addr = 24'h777777;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 400 && done_cnt == 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    pc = $countones(m);
    chk(n_wr == pc, "R3", "write count", n_wr, pc);
    chk(rd_cnt == pc, "R3", "read count", rd_cnt, pc);
    chk(!req_err, "R5", "request held until ack", req_err, 0);
    ea = a; j = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i] && j < 16 && j < n_wr) begin
        d = mem_model(ea);
        chk(log_idx[j] == 4'(i), "R3", "write index", log_idx[j], i);
        if (lg) begin
          chk(log_data[j] == d && !log_lo[j], "R6", "long data", log_data[j], d);
        end else if (i >= 8) begin
          ed = {{16{d[15]}}, d[15:0]};
          chk(log_data[j] == ed && !log_lo[j], "R7", "sign-extended word", log_data[j], ed);
        end else begin
          ed = {16'h0000, d[15:0]};
          chk(log_data[j] == ed && log_lo[j], "R8", "low-half word", log_data[j], ed);
        end
        j++;
      end
      if (m[i]) ea = ea + (lg ? AW'(4) : AW'(2));
    end
    chk(fin_addr == ea, "R4", "final address", 32'(fin_addr), 32'(ea));
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(!busy, "R9", "idle after done", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; base_addr = '0; mask = '0; long_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R1", "outputs in reset",
        {busy, done, mem_req, rf_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R1", "outputs after reset",
        {busy, done, mem_req, rf_we}, 0);

    for (int v = 0; v < int'(NV); v++)
      run_op(VEC[v][AW-1:0], VEC[v][AW+15:AW], VEC[v][AW+16], v % 3, 1'b0);

    // R10: empty mask
    run_op(24'h123456, 16'h0000, 1'b1, 0, 1'b0);
    chk(fin_addr == 24'h123456, "R10", "empty mask final address", 32'(fin_addr), 32'h123456);

    // R2: start while busy ignored (log checked inside run_op)
    run_op(24'h00C000, 16'h8001, 1'b1, 3, 1'b1);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1 && !busy, "R2", "no second run from busy start", done_cnt, 1);

    // R1: reset during an operation
    lat_cfg = 5; base_addr = 24'h000800; mask = 16'hFFFF; long_sel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req && !rf_we && !done, "R1", "mid-run reset",
        {busy, done, mem_req, rf_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule